// File: doc/BRIEF.md
# Pipelined Converter Code Alignment and Overlap Correction

This block takes the 2-bit decisions of a seven-stage pipelined analog-to-digital converter and turns them into one 8-bit sample word per clock. The first six stages are redundant 1.5-bit stages whose decisions may only be 00, 01 or 10. The seventh stage is a plain 2-bit stage that may give any of the four codes. Because stage k of a sample decides k-1 clocks after stage 1 of that sample, the block first holds each stage's code back by a stage-dependent number of clocks. Once all seven codes of one sample are lined up, it adds them. Each code overlaps its neighbour by one bit: the low bit of one stage sits at the same weight as the high bit of the next stage.

The redundancy is what lets the converter tolerate comparator offsets. When a 1.5-bit stage decides too early or too late, the later stages receive a residue that is still in range, and the overlapped addition then carries the difference back into the correct bits. A stage-1 valid flag travels with each sample. The block produces results continuously for as long as samples keep arriving. A code 11 from a 1.5-bit stage cannot happen in a healthy converter, so the block saturates the word and flags that sample.

Top module: `adc_digital_corr`

## Requirements
- R1: `stage_code_i` carries stage k (k = 1 for the stage that decides first) in bits [2k-1:2k-2].
- R2: The code on the stage-k field belongs to the sample whose stage-1 code and `valid_i` were presented k-1 clocks earlier. The stage-7 code is used in the clock it is presented.
- R3: For a sample with legal codes c1..c7, `data_o` equals the sum of ck·2^(7-k). Each stage's low bit shares a weight with the next stage's high bit.
- R4: A sample presented with `valid_i` in one clock appears with `valid_o` high exactly 7 rising edges later. Each clock of `valid_i` yields one result, in order, and clocks without `valid_i` yield none.
- R5: If any of stages 1 to 6 gives code 11, or the sum exceeds 255, `data_o` is 255 and `ovf_o` is 1 for that sample.
- R6: Code 11 from stage 7 is legal and adds 3 without raising `ovf_o`. The largest legal word is 255 (stages 1 to 6 at 10, stage 7 at 11).
- R7: While `rst_ni` is low, `valid_o`, `ovf_o` and `data_o` are 0.
- R8: `ovf_o` is 1 only in clocks where `valid_o` is 1.
- R9: For codes produced by an ideal 1.5-bit chain whose comparator thresholds are shifted by up to 1/8 of full scale, `data_o` equals the ideal 8-bit quantization of the input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Stage-1 code of a new sample is present |
| stage_code_i | input | 14 | Decision codes of the seven stages, packed as in R1 |
| valid_o | output | 1 | Corrected word valid |
| data_o | output | 8 | Corrected sample word |
| ovf_o | output | 1 | Sample saturated because of an illegal code or an oversized sum |

## Verification
The hardest condition to reach is a stream in which every stage holds a different sample at the same time. A comparator offset in one stage then has to be undone by carries that originate in later stages of that same sample. Directed words cannot produce this naturally. The bench therefore models the analog chain itself: it draws random inputs, shifts every comparator threshold by a random offset of up to 1/8 of full scale, and generates the stage decisions that such a chain would make. It feeds each stage's code onto the bus with the correct skew, back to back and across a gap. Every word must then equal the ideal quantization of its input.

// File: rtl/adc_corr_pkg.sv
package adc_corr_pkg;
  localparam int unsigned CODE_W = 2;
  typedef logic [CODE_W-1:0] code_t;
  localparam code_t CODE_ILLEGAL = 2'b11;
endpackage

// File: rtl/adc_corr_delay.sv
module adc_corr_delay #(
  parameter int unsigned WIDTH = 2,
  parameter int unsigned DEPTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) pipe_q[i] <= '0;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < int'(DEPTH); i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[DEPTH-1];
endmodule

// File: rtl/adc_corr_sum.sv
module adc_corr_sum
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTAGES = 7,
  localparam int unsigned ACC_W = NSTAGES + 2
) (
  input  logic [CODE_W*NSTAGES-1:0] codes_i,
  output logic [ACC_W-1:0]          sum_o
);
  // bitwise sum/carry chain: s = a^b^c, carry = a.b | c.(a^b)
  function automatic logic [ACC_W-1:0] ripple(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [ACC_W-1:0] s;
    logic cy;
    cy = 1'b0;
    for (int i = 0; i < int'(ACC_W); i++) begin
      s[i] = a[i] ^ b[i] ^ cy;
      cy   = (a[i] & b[i]) | (cy & (a[i] ^ b[i]));
    end
    return s;
  endfunction

  always_comb begin
    logic [ACC_W-1:0] acc;
    acc = ACC_W'(codes_i[CODE_W-1:0]);
    // shift by one, not two: one-bit overlap between neighbouring stages
    for (int k = 1; k < int'(NSTAGES); k++)
      acc = ripple(acc << 1, ACC_W'(codes_i[CODE_W*k +: CODE_W]));
    sum_o = acc;
  end
endmodule

// File: rtl/adc_digital_corr.sv
module adc_digital_corr
  import adc_corr_pkg::*;
#(
  parameter int unsigned NSTAGES = 7,
  localparam int unsigned OUT_W = NSTAGES + 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [CODE_W*NSTAGES-1:0] stage_code_i,
  output logic                      valid_o,
  output logic [OUT_W-1:0]          data_o,
  output logic                      ovf_o
);
  localparam int unsigned ACC_W = NSTAGES + 2;
  localparam int unsigned CNT_W = $clog2(NSTAGES + 1);

  logic [CODE_W*NSTAGES-1:0] aligned;
  logic                      aligned_vld;
  logic [ACC_W-1:0]          sum;
  logic                      illegal;
  logic                      sat;

  // stage k waits NSTAGES-k clocks; last stage passes straight through
  for (genvar k = 0; k < int'(NSTAGES); k++) begin : g_skew
    localparam int unsigned DLY = NSTAGES - 1 - k;
    if (DLY == 0) begin : g_pass
      assign aligned[CODE_W*k +: CODE_W] = stage_code_i[CODE_W*k +: CODE_W];
    end else begin : g_dly
      adc_corr_delay #(.WIDTH(CODE_W), .DEPTH(DLY)) u_dly (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (stage_code_i[CODE_W*k +: CODE_W]),
        .q_o   (aligned[CODE_W*k +: CODE_W])
      );
    end
  end

  adc_corr_delay #(.WIDTH(1), .DEPTH(NSTAGES - 1)) u_vld_dly (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (valid_i),
    .q_o   (aligned_vld)
  );

  adc_corr_sum #(.NSTAGES(NSTAGES)) u_sum (
    .codes_i(aligned),
    .sum_o  (sum)
  );

  always_comb begin
    illegal = 1'b0;
    for (int k = 0; k < int'(NSTAGES) - 1; k++)
      if (aligned[CODE_W*k +: CODE_W] == CODE_ILLEGAL) illegal = 1'b1;
  end

  assign sat = illegal | (|sum[ACC_W-1:OUT_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ovf_o   <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= aligned_vld;
      ovf_o   <= aligned_vld & sat;
      data_o  <= sat ? '1 : sum[OUT_W-1:0];
    end
  end

  // ---- assertions ----
  logic [CNT_W-1:0] fill_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fill_cnt <= '0;
    else if (fill_cnt != CNT_W'(NSTAGES)) fill_cnt <= fill_cnt + 1'b1;
  end

  assert_fill_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> fill_cnt == CNT_W'(NSTAGES));

  assert_clamp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> data_o == {OUT_W{1'b1}});

  assert_ovf_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> valid_o);

  assert_last_stage_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ovf_o) |-> data_o[0] == $past(stage_code_i[CODE_W*(NSTAGES-1)]));
endmodule

// File: tb/adc_digital_corr_bench.sv
`timescale 1ns/1ps
module adc_digital_corr_bench;
  localparam int N    = 7;
  localparam int SMAX = 600;
  localparam int SC   = 32768;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_ni;
  logic           valid_i;
  logic [2*N-1:0] stage_code_i;
  logic           valid_o;
  logic [7:0]     data_o;
  logic           ovf_o;

  adc_digital_corr u_adc_digital_corr (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .stage_code_i(stage_code_i),
    .valid_o(valid_o), .data_o(data_o), .ovf_o(ovf_o)
  );

  int errors = 0, checks = 0, cyc = 0, base = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [1:0] sc [SMAX][N];
  bit         sv [SMAX];
  int         nslots = 0;
  int q_data[$], q_ovf[$], q_slot[$];
  string q_req[$];
  int off_hi [N], off_lo [N];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected word from R3/R5/R6
  task automatic add_sample(input int c [N], input int exp_override, input string req);
    int sum = 0;
    bit bad = 1'b0;
    for (int k = 0; k < N; k++) begin
      sum += c[k] << (N - 1 - k);
      if (k < N - 1 && c[k] == 3) bad = 1'b1;
      sc[nslots][k] = c[k][1:0];
    end
    sv[nslots] = 1'b1;
    if (bad || sum > 255) begin
      q_data.push_back(255); q_ovf.push_back(1);
    end else begin
      q_data.push_back(exp_override >= 0 ? exp_override : sum); q_ovf.push_back(0);
    end
    q_slot.push_back(nslots);
    q_req.push_back(req);
    nslots++;
  endtask

  task automatic add_gap(input int n);
    for (int i = 0; i < n; i++) begin
      sv[nslots] = 1'b0;
      nslots++;
    end
  endtask

  // ideal 1.5-bit chain with shifted thresholds, final 2-bit stage
  task automatic add_analog(input int xf);
    int c [N];
    int v, d, f;
    v = xf - SC;
    for (int k = 0; k < N - 1; k++) begin
      if (v > SC/4 + off_hi[k]) d = 1;
      else if (v < -SC/4 + off_lo[k]) d = -1;
      else d = 0;
      c[k] = d + 1;
      v = 2*v - d*SC;
    end
    f = (v + SC < 0) ? 0 : ((v + SC) * 2) / SC;
    if (f > 3) f = 3;
    c[N-1] = f;
    add_sample(c, xf >> 8, "R9");
  endtask

  task automatic play;
    @(posedge clk); #1;
    base = cyc;
    for (int t = 0; t < nslots + N; t++) begin
      valid_i = (t < nslots) ? sv[t] : 1'b0;
      for (int k = 0; k < N; k++) begin
        int src;
        src = t - k;
        if (src >= 0 && src < nslots && sv[src]) stage_code_i[2*k +: 2] = sc[src][k];
        else stage_code_i[2*k +: 2] = 2'b11;
      end
      @(posedge clk); #1;
    end
    valid_i = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (valid_o) begin
        if (q_data.size() == 0) begin
          check(1'b0, "R4 unexpected valid_o", 1, 0);
        end else begin
          int ed, eo, es;
          string rq;
          ed = q_data.pop_front(); eo = q_ovf.pop_front();
          es = q_slot.pop_front(); rq = q_req.pop_front();
          check(data_o == 8'(ed), rq, data_o, ed);
          check(ovf_o == eo[0], {rq, " ovf"}, ovf_o, eo);
          check(cyc - base - es == 7, "R4 latency", cyc - base - es, 7);
        end
      end else if (ovf_o) begin
        check(1'b0, "R8 ovf without valid", 1, 0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    valid_i = 1'b0;
    stage_code_i = '1;
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R7 valid_o", valid_o, 0);
    check(data_o == 8'd0, "R7 data_o", data_o, 0);
    check(ovf_o == 1'b0, "R7 ovf_o", ovf_o, 0);
    @(posedge clk); #1 rst_ni = 1'b1;

    for (int k = 0; k < N; k++) begin
      off_hi[k] = int'($urandom_range(0, SC/4)) - SC/8;
      off_lo[k] = int'($urandom_range(0, SC/4)) - SC/8;
    end

    add_sample('{0,0,0,0,0,0,0}, -1, "R3 zero");
    add_sample('{2,2,2,2,2,2,3}, -1, "R6 max legal");
    add_sample('{1,0,0,0,0,0,0}, -1, "R1 stage1 weight");
    add_sample('{0,0,0,0,0,1,3}, -1, "R6 stage7 code 3");
    add_sample('{1,2,0,1,2,0,2}, -1, "R3 mixed");
    add_sample('{1,1,1,1,1,1,1}, -1, "R3 overlap carries");
    add_sample('{3,0,0,0,0,0,0}, -1, "R5 stage1 illegal");
    add_sample('{0,0,0,0,0,3,0}, -1, "R5 stage6 illegal");
    add_sample('{0,0,0,0,0,0,2}, -1, "R2 last stage only");
    add_gap(3);
    add_analog(0);
    add_analog(65535);
    add_gap(1);
    for (int i = 0; i < 400; i++) add_analog(int'($urandom_range(0, 65535)));

    play();
    repeat (N + 4) @(posedge clk);
    @(negedge clk);
    check(q_data.size() == 0, "R4 all results delivered", q_data.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule